// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block sits between software, a set of trigger sources and a multi-channel ADC sequencer. It decides when each channel may start a conversion. Software programs it through a single control word on a plain write port. Each channel carries a 4-bit code that selects the trigger it listens to: a one-shot software pulse, a software level that keeps re-triggering, a periodic tick from an internal counter, or that channel's own hardware trigger line. Captured triggers wait as pending flags. They are issued one at a time as start-of-conversion pulses, and a new one is issued only after the converter reports that the current conversion is done.

A suspend bit keeps new conversions from starting while triggers continue to be captured. Taking a channel's enable low flushes that channel's pending trigger, so triggers captured during suspend can be discarded before suspend is released. A manual mode masks every automatic trigger. In manual mode, software drives the sample-hold and the conversion request directly for a selected analog input: one of twelve external inputs, the temperature sensor or the internal reference.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset the control readback is all zero, and `soc`, `sh_en` and `conv_req` are 0.
- R2: Writing 1 to control bit 4 (one-shot) reads back 1 for exactly one cycle and then 0. Each enabled channel with source code 4'h1 gets exactly one `soc` pulse per such write.
- R3: Control bit 3 (level trigger) stays set until software clears it. While it is set, enabled channels with source code 4'h2 keep receiving new `soc` pulses.
- R4: With control bit 1 (periodic enable) set, channels with source code 4'h3 are triggered every `period`+1 cycles.
- R5: An enabled channel with source code 4'h4 is triggered while its `hw_trig` bit is 1. Channels with other codes ignore `hw_trig`. During a conversion started by a trigger, `conv_req` is 1 until `conv_done` and `conv_ch` carries the channel index.
- R6: While control bit 2 (suspend) is 1, no `soc` is issued, but triggers are still captured. They start once suspend is cleared.
- R7: A channel whose `ch_en` goes 0 and then back to 1 loses its pending trigger and receives no `soc` for it.
- R8: At most one `soc` bit is high at a time. A new `soc` follows only after `conv_done`. Channels pending together are served in ascending index order.
- R9: Several triggers captured for one channel before it is served produce a single `soc`.
- R10: While control bit 0 (manual mode) is 1, no `soc` is issued. One-shot, level, periodic and hardware triggers are neither acted on nor left pending.
- R11: In manual mode, control bit 5 (sample) drives `sh_en` high and `conv_ch` equals the select field in bits 10:7. Select codes 4'hE and 4'hF give `sh_en`=0 and `conv_req`=0.
- R12: In manual mode, writing 1 to bit 6 (convert request) sets it, and writing 0 to it has no effect. While it is set it drops `sh_en` and raises `conv_req` for select codes up to 4'hD. It reads back 1 until `conv_done` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 11 | Control word: 0 manual, 1 periodic, 2 suspend, 3 level, 4 one-shot, 5 sample, 6 convert request, 10:7 select |
| period | input | CW (8) | Periodic trigger count; the tick repeats every period+1 cycles |
| ch_en | input | NCH (4) | Per-channel enable; 0 flushes that channel's pending trigger |
| ch_src | input | 4*NCH (16) | Per-channel trigger source codes, channel i in bits 4i+3:4i |
| hw_trig | input | NCH (4) | Per-channel hardware trigger lines |
| conv_done | input | 1 | Converter signals the end of a conversion |
| ctrl_rd | output | 11 | Live control readback, same layout as wr_data |
| soc | output | NCH (4) | One-cycle start-of-conversion pulse per channel |
| sh_en | output | 1 | Sample-hold enable (manual mode) |
| conv_ch | output | 4 | Converter input select |
| conv_req | output | 1 | Conversion in progress or requested |

## Verification
The hardest state to reach is a suspended block holding several pending flags when some of them are flushed. Reaching it needs a one-shot fired under suspend, then an enable pulse on exactly the channels to be flushed, then release, all before the converter model answers. The bench sweeps every flush mask over four channels and every mix of one-shot channels. It records the order of the start pulses and compares it with the ascending list of surviving channels. A separate pass holds every trigger source active under manual mode and then leaves manual mode, so that an illegally latched trigger would show up as a late pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // control word layout
  localparam int CTRL_W   = 11;
  localparam int B_MANUAL = 0;
  localparam int B_PERIOD = 1;
  localparam int B_SUSP   = 2;
  localparam int B_LEVEL  = 3;
  localparam int B_ONCE   = 4;
  localparam int B_SAMP   = 5;
  localparam int B_CVT    = 6;
  localparam int B_SEL_LO = 7;
  localparam int SEL_W    = 4;
  localparam int SRC_W    = 4;

  // highest select code that maps to a real analog input
  localparam logic [SEL_W-1:0] SEL_MAX = 4'hD;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE   = 4'h0,
    SRC_ONCE   = 4'h1,
    SRC_LEVEL  = 4'h2,
    SRC_PERIOD = 4'h3,
    SRC_HW     = 4'h4
  } src_e;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              conv_done,
  output logic              manual,
  output logic              per_en,
  output logic              susp,
  output logic              level,
  output logic              once,
  output logic              samp,
  output logic              cvt,
  output logic [SEL_W-1:0]  sel,
  output logic [CTRL_W-1:0] rd
);
  logic manual_n, once_n, cvt_n;

  always_comb begin
    manual_n = wr_en ? wr_data[B_MANUAL] : manual;
    // one-shot lives for the single cycle after its write
    once_n   = wr_en & wr_data[B_ONCE];
    // write-one-to-set, cleared by the converter, dropped outside manual mode
    cvt_n    = manual_n & ((cvt & ~conv_done) | (wr_en & wr_data[B_CVT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      manual <= 1'b0;
      per_en <= 1'b0;
      susp   <= 1'b0;
      level  <= 1'b0;
      samp   <= 1'b0;
      sel    <= '0;
    end else if (wr_en) begin
      manual <= wr_data[B_MANUAL];
      per_en <= wr_data[B_PERIOD];
      susp   <= wr_data[B_SUSP];
      level  <= wr_data[B_LEVEL];
      samp   <= wr_data[B_SAMP];
      sel    <= wr_data[B_SEL_LO +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      once <= 1'b0;
      cvt  <= 1'b0;
    end else begin
      once <= once_n;
      cvt  <= cvt_n;
    end
  end

  assign rd = {sel, cvt, samp, once, level, susp, per_en, manual};
endmodule

// File: rtl/adc_trig_period.sv
module adc_trig_period #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          tick
);
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    tick  = run & (cnt >= period);
    cnt_n = (!run || tick) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/adc_trig_arb.sv
module adc_trig_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig,
  input  logic [NCH-1:0] ch_en,
  input  logic           hold,
  input  logic           conv_done,
  output logic [NCH-1:0] soc,
  output logic           busy,
  output logic [CHW-1:0] idx
);
  logic [NCH-1:0] pend, pend_n;
  logic [CHW-1:0] gidx;
  logic           found, go, busy_n;

  // lowest pending index wins
  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && !found) begin
        found = 1'b1;
        gidx  = CHW'(i);
      end
    end
    go  = found & ~busy & ~hold;
    soc = '0;
    if (go) soc[gidx] = 1'b1;
    busy_n = go | (busy & ~conv_done);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_pend
    // a new trigger wins over the grant clearing the flag; enable low flushes
    assign pend_n[i] = ch_en[i] & (trig[i] | (pend[i] & ~soc[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= pend_n[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx <= '0;
    else if (go) idx <= gidx;
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic [CW-1:0]      period,
  input  logic [NCH-1:0]     ch_en,
  input  logic [SRC_W*NCH-1:0] ch_src,
  input  logic [NCH-1:0]     hw_trig,
  input  logic               conv_done,
  output logic [CTRL_W-1:0]  ctrl_rd,
  output logic [NCH-1:0]     soc,
  output logic               sh_en,
  output logic [SEL_W-1:0]   conv_ch,
  output logic               conv_req
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic             manual, per_en, susp, level, once, samp, cvt, tick;
  logic [SEL_W-1:0] sel;
  logic [NCH-1:0]   trig;
  logic             hw_busy, sel_ok;
  logic [CHW-1:0]   hw_idx;

  adc_trig_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .conv_done(conv_done), .manual(manual), .per_en(per_en), .susp(susp),
    .level(level), .once(once), .samp(samp), .cvt(cvt), .sel(sel),
    .rd(ctrl_rd)
  );

  adc_trig_period #(.CW(CW)) u_period (
    .clk(clk), .rst_n(rst_n), .run(per_en & ~manual), .period(period),
    .tick(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_src
    logic [SRC_W-1:0] code;
    assign code    = ch_src[SRC_W*i +: SRC_W];
    assign trig[i] = ~manual & (((code == SRC_ONCE)   & once)  |
                                ((code == SRC_LEVEL)  & level) |
                                ((code == SRC_PERIOD) & tick)  |
                                ((code == SRC_HW)     & hw_trig[i]));
  end

  adc_trig_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ch_en(ch_en),
    .hold(susp | manual), .conv_done(conv_done), .soc(soc),
    .busy(hw_busy), .idx(hw_idx)
  );

  always_comb begin
    sel_ok   = (sel <= SEL_MAX);
    sh_en    = manual & samp & ~cvt & sel_ok;
    conv_req = manual ? (cvt & sel_ok) : hw_busy;
    conv_ch  = manual ? sel : SEL_W'(hw_idx);
  end
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk
  import adc_trig_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              conv_done,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic [NCH-1:0]    soc,
  input logic              sh_en,
  input logic              conv_req
);
  p_once_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_ONCE] && !wr_en |=> !ctrl_rd[B_ONCE]);

  p_no_soc_suspended_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_SUSP] |-> soc == '0);

  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(soc));

  p_soc_starts_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soc != '0) && !wr_en |=> conv_req);

  p_no_soc_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_MANUAL] |-> soc == '0);

  p_bad_sel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_MANUAL] && (ctrl_rd[B_SEL_LO +: SEL_W] > SEL_MAX)
      |-> !sh_en && !conv_req);

  p_cvt_ends_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_MANUAL] && conv_req |-> !sh_en);

  p_cvt_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[B_MANUAL] && conv_req && !conv_done && !wr_en |=> conv_req);
endmodule

bind adc_trig_ctrl adc_trig_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .conv_done(conv_done),
  .ctrl_rd(ctrl_rd), .soc(soc), .sh_en(sh_en), .conv_req(conv_req)
);

// File: tb/adc_trig_ctrl_tb.sv
`timescale 1ns/1ps
module adc_trig_ctrl_tb;
  localparam int NCH = 4, CW = 8, CTW = 11, LAT = 1;
  localparam int MAN = 1, PER = 2, SUSP = 4, LVL = 8, ONCE = 16, SAMP = 32, CVT = 64;

  logic             clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [CTW-1:0]   wr_data = '0;
  logic [CW-1:0]    period = '0;
  logic [NCH-1:0]   ch_en = '0, hw_trig = '0;
  logic [4*NCH-1:0] ch_src = '0;
  logic             resp_done = 1'b0, man_done = 1'b0, auto_done = 1'b1;
  logic             conv_done;
  logic [CTW-1:0]   ctrl_rd;
  logic [NCH-1:0]   soc;
  logic             sh_en, conv_req;
  logic [3:0]       conv_ch;

  assign conv_done = resp_done | man_done;

  adc_trig_ctrl #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .period(period), .ch_en(ch_en), .ch_src(ch_src), .hw_trig(hw_trig),
    .conv_done(conv_done), .ctrl_rd(ctrl_rd), .soc(soc), .sh_en(sh_en),
    .conv_ch(conv_ch), .conv_req(conv_req)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_err = 0, cyc = 0, rcnt = 0;
  int soc_cnt [NCH];
  int base [NCH];
  int ord [0:1023];
  int ord_n = 0, ord_base = 0, last_soc = -1, gap = 0, last_ch = -1;
  bit done_flag = 0;

  initial for (int i = 0; i < NCH; i++) soc_cnt[i] = 0;

  // monitor and converter model, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    resp_done = 1'b0;
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (soc[i]) begin
          soc_cnt[i]++;
          if (ord_n < 1024) ord[ord_n] = i;
          ord_n++;
        end
      end
      if (|soc) begin
        if (last_soc >= 0) gap = cyc - last_soc;
        last_soc = cyc;
      end
      if (conv_req && !ctrl_rd[0]) last_ch = int'(conv_ch);
      if (auto_done && conv_req) begin
        if (rcnt == LAT) begin resp_done = 1'b1; rcnt = 0; end
        else rcnt++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = CTW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    for (int i = 0; i < NCH; i++) base[i] = soc_cnt[i];
    ord_base = ord_n;
  endtask

  function automatic int got(input int i);
    return soc_cnt[i] - base[i];
  endfunction

  function automatic int total();
    int t = 0;
    for (int i = 0; i < NCH; i++) t += got(i);
    return t;
  endfunction

  task automatic set_src(input logic [3:0] c0, c1, c2, c3);
    ch_src = {c3, c2, c1, c0};
  endtask

  // expects one pulse for each set bit, issued in ascending index order
  task automatic chk_mask(input string tag, input logic [NCH-1:0] m);
    int k = ord_base;
    for (int i = 0; i < NCH; i++) chk({tag, " count"}, got(i), int'(m[i]));
    for (int i = 0; i < NCH; i++) begin
      if (m[i]) begin
        chk({tag, " R8 order"}, ord[k], i);
        k++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 ctrl_rd", int'(ctrl_rd), 0);
    chk("R1 soc", int'(soc), 0);
    chk("R1 conv_req", int'(conv_req), 0);
    chk("R1 sh_en", int'(sh_en), 0);

    ch_en = '1;
    // R2 / R8: every mix of one-shot channels, served in ascending order
    for (int m = 1; m < 16; m++) begin
      set_src(m[0] ? 4'h1 : 4'h0, m[1] ? 4'h1 : 4'h0,
              m[2] ? 4'h1 : 4'h0, m[3] ? 4'h1 : 4'h0);
      snap();
      wr(ONCE);
      if (m == 1) begin
        chk("R2 once reads 1", int'(ctrl_rd[4]), 1);
        idle(1);
        chk("R2 once self-clears", int'(ctrl_rd[4]), 0);
      end
      idle(30);
      chk_mask("R2 one-shot", NCH'(m));
    end

    // R3 level trigger keeps converting
    set_src(4'h0, 4'h0, 4'h2, 4'h0);
    snap();
    wr(LVL);
    idle(5);
    chk("R3 level bit held", int'(ctrl_rd[3]), 1);
    idle(40);
    chk("R3 repeated", int'(got(2) >= 8), 1);
    wr(0);
    idle(10);
    snap();
    idle(20);
    chk("R3 stops after clear", total(), 0);

    // R4 periodic tick interval sweep
    set_src(4'h0, 4'h3, 4'h0, 4'h0);
    foreach (ord[j]) if (j < 5) begin
      int p;
      p = (j == 0) ? 4 : (j == 1) ? 5 : (j == 2) ? 7 : (j == 3) ? 10 : 13;
      period = CW'(p);
      snap();
      wr(PER);
      idle(10 * (p + 1) + 5);
      wr(0);
      chk("R4 interval", gap, p + 1);
      chk("R4 count", int'(got(1) >= 8), 1);
      idle(20);
    end

    // R5 hardware trigger, only on code 4
    set_src(4'h0, 4'h0, 4'h0, 4'h4);
    snap();
    @(negedge clk);
    hw_trig = 4'b1100;
    @(negedge clk);
    hw_trig = '0;
    idle(2);
    chk("R5 conv_req during conversion", int'(conv_req), 1);
    idle(10);
    chk_mask("R5 hw", 4'b1000);
    chk("R5 conv_ch", last_ch, 3);
    chk("R5 conv_req released", int'(conv_req), 0);

    // R6 / R7 / R8: suspend, flush every mask, release
    set_src(4'h1, 4'h1, 4'h1, 4'h1);
    for (int f = 0; f < 16; f++) begin
      wr(SUSP);
      snap();
      wr(SUSP | ONCE);
      idle(4);
      chk("R6 held in suspend", total(), 0);
      ch_en = ~NCH'(f);
      idle(1);
      ch_en = '1;
      idle(1);
      wr(0);
      idle(25);
      chk_mask("R7 flush", ~NCH'(f));
    end

    // R9 repeated triggers give one start
    set_src(4'h1, 4'h0, 4'h0, 4'h0);
    wr(SUSP);
    snap();
    wr(SUSP | ONCE);
    wr(SUSP | ONCE);
    wr(SUSP | ONCE);
    wr(0);
    idle(20);
    chk_mask("R9 single pending", 4'b0001);

    // R10 manual mode masks everything and leaves nothing pending
    set_src(4'h1, 4'h2, 4'h3, 4'h4);
    period = CW'(4);
    snap();
    wr(MAN | PER | LVL | ONCE);
    hw_trig = '1;
    idle(30);
    chk("R10 no soc in manual", total(), 0);
    chk("R10 no request", int'(conv_req), 0);
    hw_trig = '0;
    wr(0);
    idle(20);
    chk("R10 nothing latched", total(), 0);

    // R11 manual sample over every select code
    auto_done = 1'b0;
    for (int s = 0; s < 16; s++) begin
      wr(MAN | SAMP | (s << 7));
      chk("R11 sh_en", int'(sh_en), int'(s <= 13));
      chk("R11 conv_ch", int'(conv_ch), s);
      chk("R11 conv_req idle", int'(conv_req), 0);
    end

    // R12 convert request
    foreach (ord[j]) if (j < 5) begin
      int s;
      s = (j == 0) ? 0 : (j == 1) ? 5 : (j == 2) ? 13 : (j == 3) ? 14 : 15;
      wr(MAN | SAMP | (s << 7));
      wr(MAN | SAMP | CVT | (s << 7));
      chk("R12 conv_req", int'(conv_req), int'(s <= 13));
      chk("R12 sampling ends", int'(sh_en), 0);
      wr(MAN | (s << 7));
      chk("R12 write 0 keeps bit", int'(ctrl_rd[6]), 1);
      chk("R12 request held", int'(conv_req), int'(s <= 13));
      @(negedge clk);
      man_done = 1'b1;
      @(negedge clk);
      man_done = 1'b0;
      chk("R12 cleared by done", int'(ctrl_rd[6]), 0);
      chk("R12 request dropped", int'(conv_req), 0);
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule